// File: doc/BRIEF.md
# Phase-Accumulator Waveform Oscillator Voice

This block is one tone voice. A 24-bit phase accumulator advances by a 16-bit frequency word on every clock and wraps around modulo 2^24. Its upper bits are turned into a 12-bit sample: a ramp, a folded triangle, or a rectangular pulse with programmable duty. A 4-bit select enables each shape independently. A pseudo-random word from a separate noise block can be passed through on its own.

The voice also produces a one-cycle flag each time the top accumulator bit goes from 0 to 1. A neighbouring voice uses this flag for phase synchronisation. The neighbouring voice's top bit comes back in as a modulation input. When ring modulation is on, that bit is XORed into the triangle's fold point.

A hold input parks the phase at zero and forces the pulse shape fully high. A synchronous clear input lets an external sync block restart the phase.

Top module: `phase_osc_voice`

## Requirements
- R1: On each clock with hold and clear both low, the accumulator becomes its previous value plus the frequency word (zero-extended), modulo 2^24.
- R2: While `test_hold` is 1 the accumulator is zero and stays there. After it is released, the first clock adds the frequency word to zero.
- R3: `sync_reset` high on a clock edge sets the accumulator to zero on that edge, instead of adding the frequency word.
- R4: Select 4'b0010 (bit 1, ramp) outputs accumulator bits [23:12].
- R5: Select 4'b0001 (bit 0, triangle) outputs bits [22:11] of the accumulator. Those bits are inverted when the fold bit is 1. The fold bit is accumulator bit 23, XORed with `mod_msb` when `ring_en` is 1.
- R6: Select 4'b0100 (bit 2, pulse) outputs 12'hFFF when accumulator bits [23:12] are greater than or equal to `pulse_width`, and 12'h000 otherwise.
- R7: While `test_hold` is 1, the pulse shape is 12'hFFF whatever `pulse_width` is.
- R8: `msb_rise` is 1 for exactly the cycle after the edge on which accumulator bit 23 changed from 0 to 1, and 0 otherwise.
- R9: Select 4'b0000 outputs zero.
- R10: Select 4'b1000 (bit 3 alone) outputs `noise_word`. Any select with bit 3 set together with another bit outputs zero.
- R11: Any select of two or three of bits 0 to 2, with bit 3 clear, outputs the bitwise AND of the chosen 12-bit shapes.
- R12: While `rst_n` is low the accumulator is zero and `msb_rise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | 16 | Phase increment added each clock |
| pulse_width | input | 12 | Pulse threshold compared with the ramp |
| test_hold | input | 1 | Holds phase at zero and forces pulse high |
| ring_en | input | 1 | Enables XOR of `mod_msb` into the triangle fold |
| mod_msb | input | 1 | Top phase bit of the modulating voice |
| sync_reset | input | 1 | Synchronous phase clear |
| wave_sel | input | 4 | Shape enables: bit0 triangle, bit1 ramp, bit2 pulse, bit3 noise |
| noise_word | input | 12 | Sample from the external noise block |
| wave_out | output | 12 | Waveform sample |
| msb_rise | output | 1 | One-cycle flag on a 0-to-1 change of phase bit 23 |

## Verification
Every phase value is visited twice with an increment of 0x1000. Pulse thresholds of 0x000, 0x800 and 0xFFF then show the exact greater-or-equal boundary and the two extreme duties. The ramp is compared against an arithmetic phase model to separate a wrong increment from a wrong bit slice. Each of the 16 selects is also run with increments of 0xFFFF and 0x3C7B, with ring modulation on and off and with the modulator bit toggling. This shows the fold-bit XOR, the AND of combined shapes, and the zeroing of noise mixes. Hold and clear are asserted in the middle of a run to show that the phase is parked, that the pulse is forced high, and that counting restarts from zero.

// File: rtl/osc_pkg.sv
package osc_pkg;
   localparam int SEL_W   = 4;
   localparam int SEL_TRI = 0;
   localparam int SEL_SAW = 1;
   localparam int SEL_PUL = 2;
   localparam int SEL_NOI = 3;
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
   parameter int ACC_W  = 24,
   parameter int FREQ_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq,
   input  logic              hold,
   input  logic              clr,
   output logic [ACC_W-1:0]  acc,
   output logic              msb_rise
);
   localparam int PAD_W = ACC_W - FREQ_W;

   logic [ACC_W-1:0] acc_next;

   assign acc_next = acc + {{PAD_W{1'b0}}, freq};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         msb_rise <= 1'b0;
      end else if (hold || clr) begin
         acc      <= '0;
         msb_rise <= 1'b0;
      end else begin
         acc      <= acc_next;
         msb_rise <= ~acc[ACC_W-1] & acc_next[ACC_W-1];
      end
   end

   assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr) |=> acc == $past(acc) + {{PAD_W{1'b0}}, $past(freq)});
   assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> acc == '0);
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc == '0);
   assert_rise_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msb_rise |-> acc[ACC_W-1]);
   assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msb_rise |=> !msb_rise);
endmodule

// File: rtl/wave_shaper.sv
module wave_shaper
   import osc_pkg::*;
#(
   parameter int ACC_W = 24,
   parameter int OUT_W = 12
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [OUT_W-1:0] pw,
   input  logic             test,
   input  logic             ring_en,
   input  logic             mod_msb,
   input  logic [SEL_W-1:0] sel,
   input  logic [OUT_W-1:0] noise,
   output logic [OUT_W-1:0] wave
);
   localparam int TOP = ACC_W - 1;

   logic             fold;
   logic [ACC_W-1:0] folded;
   logic [OUT_W-1:0] saw_w, tri_w, pul_w, mix_w;

   assign saw_w  = acc[TOP -: OUT_W];
   assign fold   = acc[TOP] ^ (ring_en & mod_msb);
   assign folded = fold ? ~acc : acc;
   assign tri_w  = folded[TOP-1 -: OUT_W];
   assign pul_w  = (test || (saw_w >= pw)) ? '1 : '0;

   assign mix_w = (sel[SEL_TRI] ? tri_w : '1)
                & (sel[SEL_SAW] ? saw_w : '1)
                & (sel[SEL_PUL] ? pul_w : '1);

   always_comb begin
      if (sel[SEL_NOI])
         wave = (sel[SEL_PUL:SEL_TRI] == '0) ? noise : '0;
      else if (sel[SEL_PUL:SEL_TRI] == '0)
         wave = '0;
      else
         wave = mix_w;
   end
endmodule

// File: rtl/phase_osc_voice.sv
module phase_osc_voice #(
   parameter int ACC_W   = 24,
   parameter int FREQ_W  = 16,
   parameter int OUT_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq_word,
   input  logic [OUT_W-1:0]  pulse_width,
   input  logic              test_hold,
   input  logic              ring_en,
   input  logic              mod_msb,
   input  logic              sync_reset,
   input  logic [3:0]        wave_sel,
   input  logic [OUT_W-1:0]  noise_word,
   output logic [OUT_W-1:0]  wave_out,
   output logic              msb_rise
);
   initial begin
      assert (ACC_W >= OUT_W + 1) else $error("ACC_W must exceed OUT_W");
      assert (FREQ_W <= ACC_W) else $error("FREQ_W must not exceed ACC_W");
   end

   logic [ACC_W-1:0] acc;
   logic [OUT_W-1:0] shaped;

   phase_acc #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .freq(freq_word), .hold(test_hold),
      .clr(sync_reset), .acc(acc), .msb_rise(msb_rise)
   );

   wave_shaper #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shape (
      .acc(acc), .pw(pulse_width), .test(test_hold), .ring_en(ring_en),
      .mod_msb(mod_msb), .sel(wave_sel), .noise(noise_word), .wave(shaped)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wave_out <= '0;
            else        wave_out <= shaped;
         end
      end else begin : g_comb
         assign wave_out = shaped;

         assert_zero_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wave_sel == 4'b0000) |-> wave_out == '0);
         assert_noise_mix_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wave_sel[3] && wave_sel[2:0] != 3'b000) |-> wave_out == '0);
         assert_test_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (test_hold && wave_sel == 4'b0100) |-> wave_out == '1);
      end
   endgenerate
endmodule

// File: tb/phase_osc_voice_bench.sv
`timescale 1ns/1ps
module phase_osc_voice_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] freq_word = '0;
   logic [11:0] pulse_width = '0;
   logic        test_hold = 1'b0, ring_en = 1'b0, mod_msb = 1'b0, sync_reset = 1'b0;
   logic [3:0]  wave_sel = '0;
   logic [11:0] noise_word = '0;
   logic [11:0] wave_out;
   logic        msb_rise;

   int vectors = 0, errors = 0, rises = 0;
   logic [23:0] macc = '0;
   logic        mrise = 1'b0;

   always #2.5 clk = ~clk;

   phase_osc_voice u_phase_osc_voice (
      .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .pulse_width(pulse_width),
      .test_hold(test_hold), .ring_en(ring_en), .mod_msb(mod_msb),
      .sync_reset(sync_reset), .wave_sel(wave_sel), .noise_word(noise_word),
      .wave_out(wave_out), .msb_rise(msb_rise)
   );

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_wave();
      logic [11:0] saw, tri_v, pul, mix;
      logic        f;
      saw   = macc[23:12];
      f     = macc[23] ^ (ring_en & mod_msb);
      tri_v = f ? ~macc[22:11] : macc[22:11];
      pul   = (test_hold || saw >= pulse_width) ? 12'hFFF : 12'h000;
      mix   = (wave_sel[0] ? tri_v : 12'hFFF) & (wave_sel[1] ? saw : 12'hFFF)
            & (wave_sel[2] ? pul : 12'hFFF);
      if (wave_sel[3]) return (wave_sel[2:0] == 0) ? noise_word : 12'h000;
      if (wave_sel[2:0] == 0) return 12'h000;
      return mix;
   endfunction

   function automatic string tag_of();
      if (wave_sel == 0) return "R9";
      if (wave_sel[3]) return "R10";
      if (test_hold && wave_sel[2]) return "R7";
      case (wave_sel)
         4'd1: return "R5";
         4'd2: return "R4";
         4'd4: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic tick();
      logic [23:0] nxt;
      @(posedge clk);
      #1;
      if (test_hold || sync_reset) begin
         macc = '0; mrise = 1'b0;
      end else begin
         nxt = macc + {8'h00, freq_word};
         mrise = !macc[23] && nxt[23];
         macc = nxt;
      end
      if (msb_rise) rises++;
   endtask

   task automatic step(string tag);
      #1;
      chk(tag, wave_out, exp_wave());
      chk("R8", {11'd0, msb_rise}, {11'd0, mrise});
      tick();
   endtask

   initial begin
      #1;
      chk("R12", {11'd0, msb_rise}, 12'd0);
      wave_sel = 4'b0010;
      #1;
      chk("R12", wave_out, 12'h000);
      @(negedge clk);
      rst_n = 1'b1;
      tick();

      // Full phase walk: every ramp value twice, three pulse thresholds
      freq_word = 16'h1000;
      rises = 0;
      for (int i = 0; i < 8192; i++) begin
         wave_sel = 4'b0010;
         step("R1");
      end
      chk("R8", 12'(rises), 12'd2);
      foreach (pulse_width[k]) begin end
      for (int p = 0; p < 3; p++) begin
         pulse_width = (p == 0) ? 12'h000 : (p == 1) ? 12'h800 : 12'hFFF;
         wave_sel = 4'b0100;
         for (int i = 0; i < 4096; i++) step("R6");
      end
      ring_en = 1'b1;
      for (int i = 0; i < 4096; i++) begin
         wave_sel = 4'b0001;
         mod_msb = i[9];
         step("R5");
      end
      ring_en = 1'b0;

      // All selects under several increments and modulation settings
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 3; c++) begin
            sync_reset = 1'b1;
            step("R3");
            sync_reset = 1'b0;
            wave_sel = 4'(s);
            #1;
            chk("R3", wave_out, exp_wave());
            freq_word   = (c == 1) ? 16'h3C7B : 16'hFFFF;
            pulse_width = (c == 0) ? 12'h800 : (c == 1) ? 12'h3A5 : 12'hC00;
            ring_en     = c[0];
            for (int i = 0; i < 300; i++) begin
               mod_msb    = ((i / 37) % 2) == 1;
               noise_word = 12'(i * 7919 + s);
               step(tag_of());
            end
         end
      end

      // Hold: phase parked, pulse forced, restart from zero
      freq_word = 16'h1000; ring_en = 1'b0; pulse_width = 12'hFFF;
      for (int i = 0; i < 100; i++) step("R1");
      test_hold = 1'b1;
      wave_sel = 4'b0010;
      step("R2");
      for (int i = 0; i < 5; i++) step("R2");
      wave_sel = 4'b0100;
      #1;
      chk("R7", wave_out, 12'hFFF);
      wave_sel = 4'b0110;
      #1;
      chk("R7", wave_out, 12'h000);
      test_hold = 1'b0;
      wave_sel = 4'b0010;
      tick();
      #1;
      chk("R2", wave_out, 12'h001);
      step("R2");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule